// File: doc/BRIEF.md
# Asynchronous Static Memory Controller

This block turns single requests from an internal port into paced access cycles on an external asynchronous device such as a static RAM, a NOR flash or a programmable logic chip. A request carries a write flag, an address, bank bits and write data. It is taken with a valid/ready handshake. The access then runs through setup, strobe and hold phases, and writes add a turnaround phase. The controller reports completion with a one-clock done pulse, and on reads it also presents the captured data.

All phase timing is counted in interface units. One unit is six system clocks, set by a free-running divider. Each phase lasts its configured count plus one unit. Two options change the basic access. The first lets an external WAIT input stretch the strobe. The second narrows chip select so that it covers only the strobe window.

Top module: `asram_ctl`

## Requirements
- R1: After reset the memory side is idle: `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_rnw` is 1, `mem_doe` is 0 and `rsp_done` is 0. `req_ready` is 1 only while idle, and only on an interface tick.
- R2: An interface tick occurs once every 6 clocks. Phase changes, and so edges of the strobes and of chip select, happen only on tick edges.
- R3: A read lowers `mem_oe_n` (rd_setup+1)*6 clocks after the access starts. It holds it low for (rd_strobe+1)*6 clocks. Without select-strobe mode, chip select rises (rd_hold+1)*6 clocks after `mem_oe_n` rises. The turnaround count does not lengthen a read.
- R4: A write lowers `mem_we_n` (wr_setup+1)*6 clocks after the start and holds it low for (wr_strobe+1)*6 clocks. Hold lasts (wr_hold+1)*6 clocks. The done pulse follows the end of hold by (turn+1)*6 clocks. `mem_rnw` is 0 while `mem_we_n` is low.
- R5: On writes, `mem_doe` is 1 from the start of setup to the end of hold, with `mem_dout` equal to the request data. `mem_doe` stays 0 on reads.
- R6: On reads, `rsp_rdata` holds the value of `mem_din` sampled on the last clock edge of the strobe phase.
- R7: `rsp_done` is a single-clock pulse. It is raised at the end of hold for reads and at the end of turnaround for writes.
- R8: With `cfg_ss` = 1, chip select is low exactly while the strobe is low. Setup and hold lengths are unchanged.
- R9: With `cfg_ew` = 1, the strobe stays low past its minimum while synchronized `mem_wait` (active high, two-flop synchronizer) is 1. It rises on the fourth tick that sees it 0. The strobe is never shorter than (strobe+1) units.
- R10: With `cfg_ew` = 0, `mem_wait` has no effect on the access timing.
- R11: `mem_addr`, `mem_bank` and `mem_rnw` keep the request's values from the start of setup to the end of hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ew | input | 1 | Enable strobe extension by `mem_wait` |
| cfg_ss | input | 1 | Chip select only during the strobe |
| cfg_rd_setup | input | CW | Read setup count |
| cfg_rd_strobe | input | CW | Read strobe count |
| cfg_rd_hold | input | CW | Read hold count |
| cfg_wr_setup | input | CW | Write setup count |
| cfg_wr_strobe | input | CW | Write strobe count |
| cfg_wr_hold | input | CW | Write hold count |
| cfg_turn | input | CW | Write turnaround count |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_bank | input | BW | Bank select |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | Access complete pulse |
| rsp_rdata | output | DW | Read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_rnw | output | 1 | 1 = read, 0 = write |
| mem_addr | output | AW | Device address |
| mem_bank | output | BW | Device bank address |
| mem_dout | output | DW | Data to device |
| mem_doe | output | 1 | Drive enable for the data bus |
| mem_din | input | DW | Data from device |
| mem_wait | input | 1 | Device wait, active high |

## Verification
The assertions assume that the configuration inputs stay stable while an access is in flight. They also assume that the device data bus changes only while output enable is low. The bench changes the configuration only between accesses, with the controller idle. Its memory model drives read data only inside the output-enable window. WAIT is driven from the falling clock edge, so the synchronizer always sees a settled value, and it is released only after the strobe has started.

// File: rtl/asram_ctl.sv
module asram_ctl #(
  parameter int AW  = 16,
  parameter int BW  = 2,
  parameter int DW  = 16,
  parameter int CW  = 4,
  parameter int DIV = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_ew,
  input  logic          cfg_ss,
  input  logic [CW-1:0] cfg_rd_setup,
  input  logic [CW-1:0] cfg_rd_strobe,
  input  logic [CW-1:0] cfg_rd_hold,
  input  logic [CW-1:0] cfg_wr_setup,
  input  logic [CW-1:0] cfg_wr_strobe,
  input  logic [CW-1:0] cfg_wr_hold,
  input  logic [CW-1:0] cfg_turn,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [BW-1:0] req_bank,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_rnw,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] mem_bank,
  output logic [DW-1:0] mem_dout,
  output logic          mem_doe,
  input  logic [DW-1:0] mem_din,
  input  logic          mem_wait
);
  localparam int DVW  = $clog2(DIV);
  localparam int WREL = 4;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STRB, S_WAITX, S_HOLD, S_TURN} st_t;

  st_t           st;
  logic [DVW-1:0] div_q;
  logic          tick;
  logic [1:0]    wsync;
  logic          wait_s;
  logic [CW-1:0] cnt, lim;
  logic [1:0]    wcnt;
  logic          wr_q, done_q;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] bank_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          busy, strobe, last;

  assign tick   = div_q == DVW'(DIV - 1);
  assign wait_s = wsync[1];
  assign last   = cnt == lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      wsync <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      wsync <= {wsync[0], mem_wait};
    end
  end

  always_comb begin
    unique case (st)
      S_SETUP: lim = wr_q ? cfg_wr_setup  : cfg_rd_setup;
      S_STRB:  lim = wr_q ? cfg_wr_strobe : cfg_rd_strobe;
      S_HOLD:  lim = wr_q ? cfg_wr_hold   : cfg_rd_hold;
      S_TURN:  lim = cfg_turn;
      default: lim = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      wcnt    <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      bank_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick) begin
        unique case (st)
          S_IDLE: if (req_valid) begin
            st      <= S_SETUP;
            cnt     <= '0;
            wr_q    <= req_wr;
            addr_q  <= req_addr;
            bank_q  <= req_bank;
            wdata_q <= req_wdata;
          end
          S_SETUP: if (last) begin
            st  <= S_STRB;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
          S_STRB: if (last) begin
            cnt <= '0;
            if (cfg_ew && wait_s) begin
              st   <= S_WAITX;
              wcnt <= '0;
            end else begin
              st <= S_HOLD;
              if (!wr_q) rdata_q <= mem_din;
            end
          end else cnt <= cnt + 1'b1;
          S_WAITX: if (wait_s) wcnt <= '0;
          else if (wcnt == 2'(WREL - 1)) begin
            st <= S_HOLD;
            if (!wr_q) rdata_q <= mem_din;
          end else wcnt <= wcnt + 1'b1;
          S_HOLD: if (last) begin
            cnt <= '0;
            if (wr_q) st <= S_TURN;
            else begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
          S_TURN: if (last) begin
            cnt    <= '0;
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else cnt <= cnt + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign busy   = st inside {S_SETUP, S_STRB, S_WAITX, S_HOLD};
  assign strobe = st inside {S_STRB, S_WAITX};

  assign req_ready = (st == S_IDLE) && tick;
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;
  assign mem_cs_n  = ~(cfg_ss ? strobe : busy);
  assign mem_oe_n  = ~(strobe & ~wr_q);
  assign mem_we_n  = ~(strobe & wr_q);
  assign mem_rnw   = ~(busy & wr_q);
  assign mem_addr  = addr_q;
  assign mem_bank  = bank_q;
  assign mem_dout  = wdata_q;
  assign mem_doe   = busy & wr_q;
endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          ss,
  input logic          ready,
  input logic          done,
  input logic          cs_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          rnw,
  input logic          doe,
  input logic [AW-1:0] addr
);
  assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cs_n && oe_n && we_n && !doe));

  assert_edge_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(oe_n) || !$stable(we_n) || !$stable(cs_n)) |-> $past(tick));

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n || we_n);

  assert_write_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !rnw);

  assert_drive_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    doe |-> !rnw);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_strobe_in_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n || !we_n) |-> !cs_n);

  assert_ss_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ss && !cs_n) |-> (!oe_n || !we_n));

  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n || !we_n) && $past(!oe_n || !we_n) |-> $stable(addr));
endmodule

bind asram_ctl asram_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ss(cfg_ss), .ready(req_ready),
  .done(rsp_done), .cs_n(mem_cs_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
  .rnw(mem_rnw), .doe(mem_doe), .addr(mem_addr)
);

// File: tb/asram_ctl_tb.sv
`timescale 1ns/1ps
module asram_ctl_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_ew = 0, cfg_ss = 0;
  logic [3:0] cfg_rd_setup = 0, cfg_rd_strobe = 0, cfg_rd_hold = 0;
  logic [3:0] cfg_wr_setup = 0, cfg_wr_strobe = 0, cfg_wr_hold = 0, cfg_turn = 0;
  logic req_valid = 0, req_wr = 0, req_ready, rsp_done;
  logic [15:0] req_addr = 0, req_wdata = 0, rsp_rdata, mem_addr, mem_dout, mem_din;
  logic [1:0] req_bank = 0, mem_bank;
  logic mem_cs_n, mem_oe_n, mem_we_n, mem_rnw, mem_doe, mem_wait = 0;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign mem_din = mem_oe_n ? 16'h0000 : (mem_addr ^ 16'h5A3C);

  asram_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_ew(cfg_ew), .cfg_ss(cfg_ss),
    .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
    .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
    .cfg_turn(cfg_turn), .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
    .req_addr(req_addr), .req_bank(req_bank), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_rnw(mem_rnw), .mem_addr(mem_addr), .mem_bank(mem_bank),
    .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din), .mem_wait(mem_wait)
  );

  // edge monitor, sampled at falling edges
  int t_cs0, t_cs1, t_st0, t_st1, t_doe0, t_doe1;
  logic p_cs = 1, p_st = 0, p_doe = 0;
  logic [15:0] s_addr, s_dout;
  logic [1:0] s_bank;
  logic s_rnw, s_doe;
  always @(negedge clk) begin
    logic st_low;
    st_low = !(mem_oe_n && mem_we_n);
    if (p_cs && !mem_cs_n) t_cs0 = cyc;
    if (!p_cs && mem_cs_n) t_cs1 = cyc;
    if (!p_st && st_low) begin
      t_st0 = cyc; s_addr = mem_addr; s_bank = mem_bank;
      s_rnw = mem_rnw; s_dout = mem_dout; s_doe = mem_doe;
    end
    if (p_st && !st_low) t_st1 = cyc;
    if (!p_doe && mem_doe) t_doe0 = cyc;
    if (p_doe && !mem_doe) t_doe1 = cyc;
    p_cs = mem_cs_n; p_st = st_low; p_doe = mem_doe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // wr ss s st h ta addr data
  localparam int NV = 6;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd0, 4'd0, 4'd0, 4'd0, 16'h0010, 16'h0000},
    {1'b0, 1'b0, 4'd2, 4'd3, 4'd1, 4'd5, 16'h1233, 16'h0000},
    {1'b1, 1'b0, 4'd0, 4'd0, 4'd0, 4'd0, 16'h00A1, 16'hBEEF},
    {1'b1, 1'b0, 4'd1, 4'd2, 4'd3, 4'd2, 16'h7F02, 16'h1357},
    {1'b0, 1'b1, 4'd1, 4'd1, 4'd2, 4'd4, 16'h4443, 16'h0000},
    {1'b1, 1'b1, 4'd2, 4'd0, 4'd1, 4'd3, 16'hC0DE, 16'hA55A}
  };

  task automatic access(input logic wr, ss, input int s, st, h, ta,
                        input logic [15:0] a, d, input logic ew, wt, input int rel);
    int t_start, st0c, c, m1, tmin, exp_len, he, t_done;
    string tg;
    tg = wr ? "R4" : "R3";
    cfg_ss = ss; cfg_ew = ew; cfg_turn = 4'(ta);
    if (wr) begin
      cfg_wr_setup = 4'(s); cfg_wr_strobe = 4'(st); cfg_wr_hold = 4'(h);
      cfg_rd_setup = 7; cfg_rd_strobe = 7; cfg_rd_hold = 7;
    end else begin
      cfg_rd_setup = 4'(s); cfg_rd_strobe = 4'(st); cfg_rd_hold = 4'(h);
      cfg_wr_setup = 7; cfg_wr_strobe = 7; cfg_wr_hold = 7;
    end
    mem_wait = wt;
    req_wr = wr; req_addr = a; req_bank = a[1:0]; req_wdata = d; req_valid = 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    t_start = cyc + 1;
    @(negedge clk);
    req_valid = 0;
    exp_len = (st + 1) * 6;
    if (rel >= 0) begin
      while (mem_oe_n && mem_we_n) @(negedge clk);
      st0c = cyc;
      repeat (rel) @(negedge clk);
      mem_wait = 0;
      c = cyc;
      m1 = c + 3;
      while ((m1 - st0c) % 6 != 0) m1++;
      tmin = st0c + (st + 1) * 6;
      exp_len = (m1 <= tmin) ? (st + 1) * 6 : m1 + 18 - st0c;
    end
    while (!rsp_done) @(negedge clk);
    t_done = cyc;
    #1;
    chk(t_st0 - t_start == (s + 1) * 6, {tg, " setup"}, t_st0 - t_start, (s + 1) * 6);
    chk(t_st1 - t_st0 == exp_len, ew ? "R9 strobe" : (wt ? "R10 strobe" : {tg, " strobe"}),
        t_st1 - t_st0, exp_len);
    he = t_st1 + (h + 1) * 6;
    if (ss) begin
      chk(t_cs0 == t_st0, "R8 cs fall", t_cs0, t_st0);
      chk(t_cs1 == t_st1, "R8 cs rise", t_cs1, t_st1);
    end else begin
      chk(t_cs0 == t_start, {tg, " cs fall"}, t_cs0, t_start);
      chk(t_cs1 == he, {tg, " hold"}, t_cs1, he);
    end
    if (wr) begin
      chk(t_done == he + (ta + 1) * 6, "R4 turnaround", t_done, he + (ta + 1) * 6);
      chk(t_doe0 == t_start, "R5 drive start", t_doe0, t_start);
      chk(t_doe1 == he, "R5 drive end", t_doe1, he);
      chk(s_doe && s_dout == d, "R5 write data", int'(s_dout), int'(d));
      chk(s_rnw == 0, "R11 rnw write", int'(s_rnw), 0);
    end else begin
      chk(t_done == he, "R7 read done", t_done, he);
      chk(rsp_rdata == (a ^ 16'h5A3C), "R6 read data", int'(rsp_rdata), int'(a ^ 16'h5A3C));
      chk(s_doe == 0, "R5 no drive", int'(s_doe), 0);
      chk(s_rnw == 1, "R11 rnw read", int'(s_rnw), 1);
    end
    chk(s_addr == a && s_bank == a[1:0], "R11 address", int'(s_addr), int'(a));
    @(negedge clk);
    chk(rsp_done == 0, "R7 pulse width", int'(rsp_done), 0);
    mem_wait = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int nr;
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n && mem_rnw && !mem_doe && !rsp_done,
        "R1 reset idle", {mem_cs_n, mem_oe_n, mem_we_n, mem_rnw, mem_doe, rsp_done}, 6'b111100);
    rst_n = 1;
    nr = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (req_ready) nr++;
    end
    chk(nr == 10, "R2 tick rate", nr, 10);
    chk(mem_cs_n && mem_rnw, "R1 idle outputs", {mem_cs_n, mem_rnw}, 2'b11);

    for (int i = 0; i < NV; i++)
      access(VEC[i][49], VEC[i][48], int'(VEC[i][47:44]), int'(VEC[i][43:40]),
             int'(VEC[i][39:36]), int'(VEC[i][35:32]), VEC[i][31:16], VEC[i][15:0],
             1'b0, 1'b0, -1);

    access(1'b0, 1'b0, 1, 1, 1, 2, 16'h2222, 16'h0, 1'b1, 1'b1, 20); // R9 extension
    access(1'b1, 1'b0, 0, 5, 0, 0, 16'h3334, 16'h9A9A, 1'b1, 1'b1, 3); // R9 minimum kept
    access(1'b1, 1'b0, 1, 0, 1, 1, 16'h0F0F, 16'h6161, 1'b1, 1'b1, 0); // R9 boundary
    access(1'b0, 1'b0, 0, 2, 0, 0, 16'h5555, 16'h0, 1'b0, 1'b1, -1); // R10 wait ignored
    access(1'b1, 1'b1, 0, 1, 0, 0, 16'h8001, 16'h0001, 1'b0, 1'b1, -1); // R10 with select-strobe

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule